// File: doc/BRIEF.md
# Fixed-Top-Window PRG Bank Latch

This block is the bank-switching logic of a cartridge that holds a single bank register. Its program ROM is split into 16 KiB banks. The CPU reaches the ROM through a 32 KiB window from $8000 to $FFFF. The lower half of that window ($8000-$BFFF) shows whichever bank the register holds. The upper half ($C000-$FFFF) is wired to the highest bank, so the startup code and interrupt vectors are always present. The block produces the full ROM address: the bank bits sit above the 14 offset bits.

The register is loaded by a CPU write to any address in $8000-$FFFF. All addresses in that range are equivalent. The ROM keeps driving the data bus during such a write. When the CPU byte and the ROM byte at the written address disagree, they fight on the bus. This block models the fight as a bitwise AND of the two bytes, and the AND result is what gets latched. Software avoids the fight by storing the bank number over a ROM byte that already holds that same value.

The register width is a parameter: 3 bits (8 banks, 128 KiB) or 4 bits (16 banks, 256 KiB).

Top module: `prg_latch_mapper`

## Requirements
- R1: A synchronous active-high reset clears the bank register to 0. After reset, a read at $8000-$BFFF yields bank 0 in the upper address bits.
- R2: A write (`cpu_wr`=1) with `cpu_addr[15]`=1 loads the register at that clock edge. The value loaded is the low BANK_W bits of `cpu_data & rom_data`. Every address from $8000 to $FFFF behaves the same way.
- R3: When `cpu_data` equals `rom_data`, the register receives exactly the bank number written.
- R4: When `cpu_data` and `rom_data` differ, the register receives their bitwise AND. For example, CPU 7 with ROM 5 latches bank 5.
- R5: A write with `cpu_addr[15]`=0 leaves the register unchanged.
- R6: When `cpu_addr[15:14]`=2'b10, `prg_rom_addr` equals {register, `cpu_addr[13:0]`}.
- R7: When `cpu_addr[14]`=1, the bank field `prg_rom_addr[BANK_W+13:14]` is all ones, whatever the register holds. The low 14 bits follow the CPU address.
- R8: Data bits at and above position BANK_W have no effect on the bank that is loaded.
- R9: During the cycle of a write, the output still reflects the old register value (or the fixed bank in the upper window). The new bank appears from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | Byte the CPU drives during a write |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| rom_data | input | 8 | Byte the ROM drives at the current address |
| prg_rom_addr | output | BANK_W+14 | ROM address: bank bits above the 14-bit offset |

## Verification
A register load and an address translation can fall in the same cycle. This happens when the CPU writes to the mapper region, because the written address is also being translated.

The bench provokes this in two ways:
- a write into the fixed upper window, where the output must still show the all-ones bank;
- a write into the switchable window, where the output must show the previous bank during the write cycle and the new bank on the following read.

The same writes are made once with matching bytes and once with conflicting bytes. The scoreboard judges each outcome by the AND-based bank that follows.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

    localparam int CPU_AW   = 16;
    localparam int DATA_W   = 8;
    localparam int OFFSET_W = 14;

    typedef enum logic [1:0] {
        WIN_BELOW  = 2'd0,
        WIN_SWITCH = 2'd1,
        WIN_FIXED  = 2'd2
    } win_e;

    function automatic win_e classify(input logic [CPU_AW-1:0] a);
        if (!a[15])     return WIN_BELOW;
        else if (a[14]) return WIN_FIXED;
        else            return WIN_SWITCH;
    endfunction

    // Both drivers are on the bus at once: a low from either wins.
    function automatic logic [DATA_W-1:0] wired_and(input logic [DATA_W-1:0] cpu_b,
                                                     input logic [DATA_W-1:0] rom_b);
        return cpu_b & rom_b;
    endfunction

endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
    import prg_map_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] rom_data,
    output logic              load_en,
    output logic [BANK_W-1:0] load_val
);
    win_e win;

    always_comb begin
        win      = classify(cpu_addr);
        load_en  = cpu_wr && (win != WIN_BELOW);
        load_val = BANK_W'(wired_and(cpu_data, rom_data));
    end
endmodule

// File: rtl/prg_bank_latch.sv
module prg_bank_latch #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [BANK_W-1:0] load_val,
    output logic [BANK_W-1:0] bank_q
);
    always_ff @(posedge clk) begin
        if (rst)          bank_q <= '0;
        else if (load_en) bank_q <= load_val;
    end

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(bank_q));
endmodule

// File: rtl/prg_addr_map.sv
module prg_addr_map
    import prg_map_pkg::*;
#(
    parameter int BANK_W = 3,
    localparam int OUT_W = BANK_W + OFFSET_W
) (
    input  logic [OFFSET_W:0]  win_addr,
    input  logic [BANK_W-1:0]  bank_q,
    output logic [OUT_W-1:0]   prg_rom_addr
);
    logic [BANK_W-1:0] bank_eff;

    // One OR gate per bank bit: address bit 14 forces the top bank.
    for (genvar i = 0; i < BANK_W; i++) begin : g_force
        assign bank_eff[i] = bank_q[i] | win_addr[OFFSET_W];
    end

    assign prg_rom_addr = {bank_eff, win_addr[OFFSET_W-1:0]};
endmodule

// File: rtl/prg_latch_mapper.sv
module prg_latch_mapper
    import prg_map_pkg::*;
#(
    parameter int BANK_W = 3,
    localparam int OUT_W = BANK_W + OFFSET_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    input  logic [7:0]        rom_data,
    output logic [OUT_W-1:0]  prg_rom_addr
);
    logic              load_en;
    logic [BANK_W-1:0] load_val;
    logic [BANK_W-1:0] bank_q;

    prg_wr_decode #(.BANK_W(BANK_W)) u_dec (
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .rom_data (rom_data),
        .load_en  (load_en),
        .load_val (load_val)
    );

    prg_bank_latch #(.BANK_W(BANK_W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .load_val (load_val),
        .bank_q   (bank_q)
    );

    prg_addr_map #(.BANK_W(BANK_W)) u_map (
        .win_addr     (cpu_addr[OFFSET_W:0]),
        .bank_q       (bank_q),
        .prg_rom_addr (prg_rom_addr)
    );

    // R2
    conflict_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15]) |=>
            (bank_q == $past(cpu_data[BANK_W-1:0] & rom_data[BANK_W-1:0])));

    // R7
    fixed_bank_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[14] |-> (prg_rom_addr[OUT_W-1:OFFSET_W] == {BANK_W{1'b1}}));

    // R6
    switch_win_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b10 && $past(cpu_wr && cpu_addr[15]) && !$past(rst)) |->
            (prg_rom_addr[OUT_W-1:OFFSET_W] ==
             $past(cpu_data[BANK_W-1:0] & rom_data[BANK_W-1:0])));

    // R5
    low_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && !cpu_addr[15]) |=> $stable(bank_q));
endmodule

// File: tb/prg_latch_mapper_bench.sv
module prg_latch_mapper_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BANK_W = 3;
    localparam int OUT_W  = BANK_W + 14;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [15:0]      cpu_addr = '0;
    logic [7:0]       cpu_data = '0;
    logic             cpu_wr = 1'b0;
    logic [7:0]       rom_data = '0;
    logic [OUT_W-1:0] prg_rom_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [BANK_W-1:0] model_bank = '0;

    logic [OUT_W-1:0] exp_q[$];
    string            tag_q[$];

    prg_latch_mapper #(.BANK_W(BANK_W)) u_prg_latch_mapper (
        .clk (clk), .rst (rst), .cpu_addr (cpu_addr), .cpu_data (cpu_data),
        .cpu_wr (cpu_wr), .rom_data (rom_data), .prg_rom_addr (prg_rom_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: present one bus cycle and queue the output the requirements predict.
    task automatic drive(input logic [15:0] a, input logic wr,
                         input logic [7:0] d, input logic [7:0] r, input string tag);
        logic [BANK_W-1:0] bank;
        @(posedge clk);
        #1;
        cpu_addr = a; cpu_wr = wr; cpu_data = d; rom_data = r;
        bank = a[14] ? {BANK_W{1'b1}} : model_bank;
        exp_q.push_back({bank, a[13:0]});
        tag_q.push_back(tag);
        if (wr && a[15]) model_bank = BANK_W'(d & r);
    endtask

    // Monitor: compare at the falling edge of the same cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [OUT_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (prg_rom_addr !== e) begin
                bad++;
                $display("FAIL %s: prg_rom_addr actual=%h expected=%h", t, prg_rom_addr, e);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000 && !finished) begin
                finished = 1;
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        drive(16'h8123, 0, 8'h00, 8'h00, "R1 reset bank 0");
        drive(16'hC456, 0, 8'h00, 8'h00, "R7 fixed bank after reset");
        for (int b = 0; b < (1 << BANK_W); b++) begin
            drive(16'h8000 + 16'(b * 16'h0411), 1, 8'(b), 8'(b), "R3 matching write");
            drive(16'hA000 + 16'(b * 16), 0, 8'h00, 8'h00, "R6 switch window bank");
            drive(16'hFFFF, 0, 8'h00, 8'h00, "R7 fixed window");
        end
        drive(16'hE000, 1, 8'h07, 8'h05, "R9 write in fixed window same cycle");
        drive(16'h8000, 0, 8'h00, 8'h00, "R4 conflict AND gives 5");
        drive(16'h9000, 1, 8'hF2, 8'hFF, "R9 old bank during write");
        drive(16'hBFFF, 0, 8'h00, 8'h00, "R8 high data bits ignored");
        drive(16'h7FFF, 1, 8'h06, 8'h06, "R7 fixed below mapper region");
        drive(16'h4000, 1, 8'h01, 8'h01, "R5 low write");
        drive(16'h8ABC, 0, 8'h00, 8'h00, "R5 bank unchanged");
        drive(16'hB000, 1, 8'h03, 8'h03, "R9 old bank 2 during write");
        drive(16'hB000, 0, 8'h00, 8'h00, "R2 new bank next cycle");
        drive(16'hC000, 1, 8'h06, 8'h03, "R2 write at C000");
        drive(16'h8001, 0, 8'h00, 8'h00, "R4 conflict AND gives 2");
        @(posedge clk);
        #1 cpu_wr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule